// File: doc/BRIEF.md
# Parallel Converter Result Reader

This block sits on the host side of a 12-bit successive-approximation converter that has a three-state parallel output bus. For each accepted read request it drives the converter's active-low chip select, active-low read strobe and a byte-select line. It then captures the result either as one full-width word or as two narrow transfers on an 8-bit bus, which it joins back into the 12-bit word. The result is presented with a one-cycle valid pulse.

A request is latched together with two mode inputs. One picks full-word or narrow-bus reading. The other picks, for narrow reads, whether each transfer gets its own strobe pulse or the strobe stays low while only byte-select changes. Each strobe assertion, and each byte-select change under a held strobe, is followed by a fixed access delay before data is sampled. The host signals an upcoming conversion start with a warning pulse. From that pulse a quiet window runs for a set number of cycles, and no new bus transaction may begin inside it.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset, chip select and read strobe are high (inactive), byte-select is low, and busy and result-valid are low.
- R2: In full-word mode (`byte_mode`=0) one transfer is made with byte-select low, and the result equals bus lines 11..0 as straight binary (line 11 is the MSB; 0x000, 0x7FF, 0x800 and 0xFFF pass unchanged).
- R3: In narrow mode (`byte_mode`=1) exactly two transfers are made, first with byte-select low and then with byte-select high. Byte-select rises once per read and returns low only while chip select is high. The result is {lines 11..4 of the first transfer, lines 11..8 of the second}.
- R4: With `split_strobe`=1 a narrow read gives two separate read-strobe falling edges. With `split_strobe`=0 it gives one, and the strobe stays low across the byte-select change. A full-word read always gives one.
- R5: Data are sampled only after the read strobe has been low for ACC_DLY cycles, and under a held strobe only after byte-select has held its new value for ACC_DLY cycles.
- R6: Chip select does not go low in the cycle of a `conv_warn` pulse or in the QUIET_PRE+QUIET_POST cycles after it. A request made together with the warning starts its transaction (chip select low) exactly QUIET_PRE+QUIET_POST+1 cycles after the warning edge. Without a window, chip select goes low one cycle after the request edge.
- R7: Each completed read gives a `res_valid` pulse exactly one cycle wide. `busy` is high from the cycle after the accepted request until the valid cycle, and low in the valid cycle.
- R8: In narrow mode `res_err` is high with the result when lines 7..4 of the second transfer are not all zero. It is always low in full-word mode.
- R9: Between two transactions chip select stays high for at least two consecutive cycles.
- R10: A request made while `busy` is high is ignored and gives no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken when busy is low |
| byte_mode | input | 1 | 1: two narrow transfers; 0: one full-word transfer |
| split_strobe | input | 1 | Narrow mode: 1 gives one strobe pulse per transfer |
| conv_warn | input | 1 | One-cycle warning that starts the quiet window |
| adc_db | input | 12 | Converter data bus |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_byte | output | 1 | Byte select; high picks the low part |
| busy | output | 1 | A read is accepted and not yet delivered |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Assembled result |
| res_err | output | 1 | Padding lines of the second narrow transfer were not zero |

## Verification
The bench's bus model returns inverted data until the strobe, or a byte-select change, has aged by the access delay. A reader that samples a cycle early therefore delivers a corrupted word instead of quietly passing. A request is made in the very cycle of a warning pulse, and the start cycle is measured. A gate that is off by one, or that ignores the warning cycle itself, shows up as a changed latency. Narrow reads are run under both strobe options with codes whose two halves differ, and the padding lines are corrupted on purpose. Swapped halves, a missing second strobe or a lost error flag each give a mismatch. Back-to-back and overlapping requests expose a missing turnaround or a duplicated result.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HIACC = 3'd1,
    ST_GAP   = 3'd2,
    ST_LOACC = 3'd3,
    ST_TURN  = 3'd4
  } rd_state_t;
endpackage

// File: rtl/adcrd_quiet.sv
module adcrd_quiet #(
  parameter int QUIET_PRE  = 2,
  parameter int QUIET_POST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  output logic blocked
);
  localparam int QW = QUIET_PRE + QUIET_POST;
  localparam int CW = (QW > 1) ? $clog2(QW + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = warn || (cnt_q != '0);
    if (warn) cnt_d = CW'(QW);
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign blocked = warn || (cnt_q != '0);
endmodule

// File: rtl/adcrd_seq.sv
module adcrd_seq
  import adcrd_pkg::*;
#(
  parameter int ACC_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic byte_mode,
  input  logic split_strobe,
  input  logic blocked,
  output logic cs_n,
  output logic rd_n,
  output logic byte_sel,
  output logic cap_hi,
  output logic cap_lo,
  output logic mode_byte,
  output logic busy
);
  localparam int CW = (ACC_DLY > 1) ? $clog2(ACC_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_DLY - 1);

  rd_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          mb_q, ss_q;
  logic          accept, done;

  assign accept = req && !busy_q;
  assign done   = (cap_hi && !mb_q) || cap_lo;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cap_hi = 1'b0;
    cap_lo = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (busy_q && !blocked) begin
          st_d  = ST_HIACC;
          cnt_d = '0;
        end
      end
      ST_HIACC: begin
        if (cnt_q == LAST) begin
          cap_hi = 1'b1;
          cnt_d  = '0;
          if (!mb_q)     st_d = ST_TURN;
          else if (ss_q) st_d = ST_GAP;
          else           st_d = ST_LOACC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        st_d  = ST_LOACC;
        cnt_d = '0;
      end
      ST_LOACC: begin
        if (cnt_q == LAST) begin
          cap_lo = 1'b1;
          st_d   = ST_TURN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_q <= 1'b0;
      ss_q <= 1'b0;
    end else if (accept) begin
      mb_q <= byte_mode;
      ss_q <= split_strobe;
    end
  end

  assign cs_n      = (st_q == ST_IDLE) || (st_q == ST_TURN);
  assign rd_n      = !((st_q == ST_HIACC) || (st_q == ST_LOACC));
  assign byte_sel  = (st_q == ST_GAP) || (st_q == ST_LOACC);
  assign mode_byte = mb_q;
  assign busy      = busy_q;

  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && cs_n) |=> cs_n);
  assert_turn_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  assert_byte_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_sel) |-> cs_n);
  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
endmodule

// File: rtl/adcrd_join.sv
module adcrd_join #(
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] db,
  input  logic             cap_hi,
  input  logic             cap_lo,
  input  logic             mode_byte,
  output logic             valid,
  output logic [RES_W-1:0] data,
  output logic             err
);
  localparam int LOW_W = RES_W - NARROW_W;
  localparam int PAD_W = NARROW_W - LOW_W;

  logic [NARROW_W-1:0] first_q;
  logic [RES_W-1:0]    res_q, res_d;
  logic                err_q, err_d, valid_q, res_en;

  always_comb begin
    res_en = (cap_hi && !mode_byte) || cap_lo;
    if (cap_lo) begin
      res_d = {first_q, db[RES_W-1 -: LOW_W]};
      err_d = |db[RES_W-LOW_W-1 -: PAD_W];
    end else begin
      res_d = db;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      first_q <= '0;
    else if (cap_hi) first_q <= db[RES_W-1 -: NARROW_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= res_en;
  end

  assign valid = valid_q;
  assign data  = res_q;
  assign err   = err_q;

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_err_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !mode_byte) |-> !err);
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl #(
  parameter int RES_W      = 12,
  parameter int NARROW_W   = 8,
  parameter int ACC_DLY    = 3,
  parameter int QUIET_PRE  = 2,
  parameter int QUIET_POST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             byte_mode,
  input  logic             split_strobe,
  input  logic             conv_warn,
  input  logic [RES_W-1:0] adc_db,
  output logic             adc_cs_n,
  output logic             adc_rd_n,
  output logic             adc_byte,
  output logic             busy,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             res_err
);
  logic blocked, cap_hi, cap_lo, mode_byte;

  adcrd_quiet #(.QUIET_PRE(QUIET_PRE), .QUIET_POST(QUIET_POST)) u_quiet (
    .clk(clk), .rst_n(rst_n), .warn(conv_warn), .blocked(blocked)
  );

  adcrd_seq #(.ACC_DLY(ACC_DLY)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .byte_mode(byte_mode),
    .split_strobe(split_strobe), .blocked(blocked),
    .cs_n(adc_cs_n), .rd_n(adc_rd_n), .byte_sel(adc_byte),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .mode_byte(mode_byte), .busy(busy)
  );

  adcrd_join #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_join (
    .clk(clk), .rst_n(rst_n), .db(adc_db), .cap_hi(cap_hi), .cap_lo(cap_lo),
    .mode_byte(mode_byte), .valid(res_valid), .data(res_data), .err(res_err)
  );

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);
endmodule

// File: tb/test_adcrd_ctrl.sv
module test_adcrd_ctrl;
  localparam int ACC = 3;
  localparam int QP  = 2;
  localparam int QQ  = 4;
  localparam int QW  = QP + QQ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, byte_mode = 1'b0, split_strobe = 1'b0, conv_warn = 1'b0;
  wire  [11:0] adc_db;
  logic adc_cs_n, adc_rd_n, adc_byte, busy, res_valid, res_err;
  logic [11:0] res_data;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  adcrd_ctrl #(.RES_W(12), .NARROW_W(8), .ACC_DLY(ACC), .QUIET_PRE(QP), .QUIET_POST(QQ)) i_adcrd_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .byte_mode(byte_mode),
    .split_strobe(split_strobe), .conv_warn(conv_warn), .adc_db(adc_db),
    .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_byte(adc_byte), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  // converter bus model: data settle after ACC cycles of strobe or byte change
  logic [11:0] cur = 12'h000;
  logic        inj = 1'b0;
  logic [7:0]  mc = 8'd0;
  logic        bs_q = 1'b0;
  logic        fresh, good;
  logic [11:0] drv;
  always_comb begin
    fresh = (adc_byte != bs_q);
    good  = ((fresh ? 8'd0 : mc) >= 8'(ACC - 1));
    drv   = adc_byte ? {cur[3:0], (inj ? 4'hA : 4'h0), 4'h0} : cur;
  end
  assign adc_db = (!adc_cs_n && !adc_rd_n) ? (good ? drv : ~drv) : 12'bz;
  always @(posedge clk) begin
    bs_q <= adc_byte;
    if (adc_cs_n || adc_rd_n) mc <= 8'd0;
    else if (fresh)           mc <= 8'd1;
    else                      mc <= mc + 8'd1;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // scoreboard
  logic [11:0] q_data[$];
  logic        q_err[$];
  int          q_rdf[$];
  int          q_bsr[$];
  string       q_tag[$];
  int rdf = 0, bsr = 0, cs_hi_run = 0;
  logic prev_rd = 1'b1, prev_bs = 1'b0, prev_cs = 1'b1, prev_val = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd && !adc_rd_n && !adc_cs_n) rdf++;
      if (!prev_bs && adc_byte) bsr++;
      if (adc_cs_n) cs_hi_run++;
      else begin
        if (prev_cs && cs_hi_run > 0) chk(cs_hi_run >= 2, "R9 cs_n high gap", cs_hi_run, 2);
        cs_hi_run = 0;
      end
      if (prev_val && res_valid) chk(1'b0, "R7 valid width", 2, 1);
      if (res_valid) begin
        chk(!busy, "R7 busy low at valid", busy, 0);
        if (q_data.size() == 0) chk(1'b0, "R10 unexpected result", res_data, 0);
        else begin
          logic [11:0] ed; logic ee; int er, eb; string tg;
          ed = q_data.pop_front(); ee = q_err.pop_front();
          er = q_rdf.pop_front();  eb = q_bsr.pop_front(); tg = q_tag.pop_front();
          chk(res_data == ed, {tg, " data"}, res_data, ed);
          chk(res_err == ee, "R8 error flag", res_err, ee);
          chk(rdf == er, "R4 strobe falls", rdf, er);
          chk(bsr == eb, "R3 byte-select rises", bsr, eb);
        end
        rdf = 0; bsr = 0;
      end
      prev_rd = adc_rd_n; prev_bs = adc_byte; prev_cs = adc_cs_n; prev_val = res_valid;
    end
  end

  task automatic push(input logic [11:0] v, input bit bm, input bit sp, input bit ij, input string tg);
    q_data.push_back(v);
    q_err.push_back(bm && ij);
    q_rdf.push_back((bm && sp) ? 2 : 1);
    q_bsr.push_back(bm ? 1 : 0);
    q_tag.push_back(tg);
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!res_valid);
  endtask

  task automatic do_read(input logic [11:0] v, input bit bm, input bit sp, input bit ij, input string tg);
    cur = v; inj = ij;
    push(v, bm, sp, ij, tg);
    rd_req = 1'b1; byte_mode = bm; split_strobe = sp;
    @(negedge clk);
    rd_req = 1'b0;
    wait_valid();
  endtask

  // request in the cycle of the warning (or without it); measure start latency
  task automatic timed_read(input bit w, input int exp_n, input string tg);
    int n;
    cur = 12'h5C3; inj = 1'b0;
    push(12'h5C3, 1'b0, 1'b0, 1'b0, tg);
    rd_req = 1'b1; byte_mode = 1'b0; conv_warn = w;
    @(negedge clk);
    rd_req = 1'b0; conv_warn = 1'b0;
    n = 0;
    while (adc_cs_n && n < 50) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == exp_n, "R6 start latency", n, exp_n);
    wait_valid();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
    chk(adc_rd_n == 1'b1, "R1 rd_n", adc_rd_n, 1);
    chk(adc_byte == 1'b0, "R1 byte", adc_byte, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 full-word codes, R5 via settling model
    do_read(12'h000, 0, 0, 0, "R2 zero");
    do_read(12'h7FF, 0, 0, 0, "R2 mid-1");
    do_read(12'h800, 0, 1, 0, "R2 mid");
    do_read(12'hFFF, 0, 0, 0, "R2 full");
    // R3/R4 narrow, both strobe options; R5 byte-change settling
    do_read(12'hA5C, 1, 1, 0, "R3 split");
    do_read(12'h3E7, 1, 0, 0, "R3 held R5");
    do_read(12'h801, 1, 1, 0, "R3 split edge");
    do_read(12'hFFF, 1, 0, 0, "R3 held full");
    // R8 padding corrupted
    do_read(12'h4B2, 1, 1, 1, "R8 split err");
    do_read(12'h19D, 1, 0, 1, "R8 held err");
    do_read(12'h19D, 0, 0, 1, "R8 word no err");
    // R6 latency without and with window
    timed_read(1'b0, 1, "R6 no window");
    timed_read(1'b1, QW + 1, "R6 window");
    // R10 request while busy ignored
    cur = 12'h2D4; inj = 1'b0;
    push(12'h2D4, 0, 0, 0, "R10 first");
    rd_req = 1'b1; byte_mode = 1'b0;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_valid();
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R10 busy after ignored req", busy, 0);
    chk(q_data.size() == 0, "R10 queue drained", q_data.size(), 0);
    // R9 back-to-back
    do_read(12'h0F0, 1, 1, 0, "R9 b2b a");
    do_read(12'h0F1, 0, 0, 0, "R9 b2b b");
    do_read(12'hE1E, 1, 0, 0, "R9 b2b c");
    repeat (5) @(negedge clk);
    chk(q_data.size() == 0, "R7 all results seen", q_data.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule